// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller for an 8-bit successive-approximation analog-to-digital converter. Software starts a conversion by writing 1 to a go/done control bit. The sequencer stops sampling and waits a start delay that depends on the selected clock source. It then runs a conversion clock and resolves one result bit per conversion-clock period, from the most significant bit down. For each bit it drives a trial code to an external DAC and reads back an external comparator.

The conversion clock comes from one of two sources. The first is derived from the system clock by a fixed divider. The second is a separate free-running RC clock, which reaches the block as a one-cycle tick strobe. At the end of a conversion the sequencer does three things: it copies the trial code into the result register, clears the go bit and raises an interrupt flag. The flag stays set until software clears it. After each completion or abort, a recovery period must pass before sampling resumes.

Top module: `sarConvSeq`

## Requirements
- R1: After reset, goBit=0, intFlag=0, result=0, dacCode=0, adClkEn=0 and sampleEn=1.
- R2: A write with goWr=1 and goWrData=1 while idle sets goBit and clears sampleEn on the next clock edge.
- R3: The start delay runs from the clock edge that accepts the GO write. adClkEn rises 1 clock later when srcRc=0. It rises 5 clocks later when srcRc=1, because one 4-clock instruction cycle is added.
- R4: The conversion clock ticks every 4 system clocks when srcRc=0. When srcRc=1, each rcTick pulse is one tick. srcRc is captured when GO is accepted.
- R5: The trial code starts at 0x80. On ticks 1 to 8 the current bit (bit 7 down to bit 0) is kept if cmpIn=1, meaning the input is at or above the trial code, and cleared if cmpIn=0. Each of these ticks also sets the next lower bit. With an ideal comparator the result equals the input code.
- R6: Completion happens on the 11th tick. At that edge result is loaded and goBit clears, and intFlag is set on the same edge. With srcRc=0, goBit falls 45 clocks after the accepting edge.
- R7: result keeps its previous value throughout a conversion.
- R8: After a completion or an abort, sampleEn returns to 1 only after 2 more conversion ticks, which is 8 clocks with srcRc=0. A GO write during this recovery is ignored.
- R9: A GO write of 1 during a conversion is ignored and does not restart or shift the conversion.
- R10: A GO write of 0 during the start delay or the conversion aborts it. goBit and adClkEn go to 0, result is unchanged and intFlag is not set.
- R11: intFlag stays at 1 until a flagClr pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| goWr | input | 1 | Write strobe for the go/done bit |
| goWrData | input | 1 | Value written to the go/done bit |
| srcRc | input | 1 | Clock source: 0 = divided system clock, 1 = RC clock |
| rcTick | input | 1 | One-cycle strobe per RC conversion-clock period |
| flagClr | input | 1 | Clears the interrupt flag |
| cmpIn | input | 1 | Comparator: 1 = input at or above dacCode |
| goBit | output | 1 | Go/done status; 1 while converting |
| sampleEn | output | 1 | Sample-and-hold tracking enable |
| adClkEn | output | 1 | Conversion clock running |
| dacCode | output | 8 | Trial code to the DAC |
| result | output | 8 | Last completed conversion result |
| intFlag | output | 1 | Conversion-complete interrupt flag |

## Verification
The hardest case to reach from the ports is a control write that lands inside a running conversion: a second GO write, or a clearing write, arriving at a chosen tick. Directed runs on the divided clock therefore place these writes at fixed clock counts after the accepting edge. They check that the completion edge does not move, or that the abort leaves the result and the flag unchanged. Random runs use a seeded comparator input and random RC tick spacing, so that the bit trials and the recovery count see irregular tick timing.

// File: rtl/sarConvSeqPkg.sv
package sarConvSeqPkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_CONV, ST_RECOV} seqState_t;

  typedef struct packed {
    logic loadTrial;
    logic stepBit;
    logic commit;
  } seqStrobe_t;
endpackage

// File: rtl/sarConvSeqCtrl.sv
module sarConvSeqCtrl
  import sarConvSeqPkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int CONV_TICKS  = 11,
  parameter int CLK_DIV     = 4,
  parameter int START_OSC   = 1,
  parameter int INSN_CLKS   = 4,
  parameter int RECOV_TICKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       goWr,
  input  logic       goWrData,
  input  logic       srcRc,
  input  logic       rcTick,
  input  logic       flagClr,
  output logic       goBit,
  output logic       sampleEn,
  output logic       adClkEn,
  output logic       intFlag,
  output seqStrobe_t strobe
);
  localparam int DIV_W  = $clog2(CLK_DIV + 1);
  localparam int DLY_W  = $clog2(START_OSC + INSN_CLKS + 1);
  localparam int TICK_W = $clog2(CONV_TICKS + 1);
  localparam int REC_W  = $clog2(RECOV_TICKS + 1);

  seqState_t        state;
  logic [DIV_W-1:0]  divCnt;
  logic [DLY_W-1:0]  dlyCnt;
  logic [TICK_W-1:0] tickCnt;
  logic [REC_W-1:0]  recCnt;
  logic srcRcLat, oscTick, tick, running, goSet, goClr, abort, lastTick;

  always_comb begin
    running  = (state == ST_CONV) || (state == ST_RECOV);
    oscTick  = running && (divCnt == DIV_W'(CLK_DIV - 1));
    tick     = running && (srcRcLat ? rcTick : oscTick);
    goSet    = goWr && goWrData;
    goClr    = goWr && !goWrData;
    abort    = goClr && ((state == ST_START) || (state == ST_CONV));
    lastTick = (state == ST_CONV) && tick && (tickCnt == TICK_W'(CONV_TICKS - 1));
    strobe.loadTrial = (state == ST_START) && (dlyCnt == '0) && !abort;
    strobe.stepBit   = (state == ST_CONV) && tick && (tickCnt < TICK_W'(WIDTH)) && !abort;
    strobe.commit    = lastTick && !abort;
    adClkEn  = (state == ST_CONV);
    sampleEn = (state == ST_IDLE);
  end

  // divided system clock: restarts whenever the running phase begins or is aborted
  always_ff @(posedge clk) begin
    if (!rstN || !running || abort || oscTick) divCnt <= '0;
    else                                       divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      goBit    <= 1'b0;
      srcRcLat <= 1'b0;
      dlyCnt   <= '0;
      tickCnt  <= '0;
      recCnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (goSet) begin
          state    <= ST_START;
          goBit    <= 1'b1;
          srcRcLat <= srcRc;
          dlyCnt   <= srcRc ? DLY_W'(START_OSC + INSN_CLKS - 1) : DLY_W'(START_OSC - 1);
        end
        ST_START: begin
          if (abort) begin
            state <= ST_RECOV;
            goBit <= 1'b0;
            recCnt <= '0;
          end else if (dlyCnt == '0) begin
            state   <= ST_CONV;
            tickCnt <= '0;
          end else begin
            dlyCnt <= dlyCnt - 1'b1;
          end
        end
        ST_CONV: begin
          if (abort || lastTick) begin
            state  <= ST_RECOV;
            goBit  <= 1'b0;
            recCnt <= '0;
          end else if (tick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_RECOV: if (tick) begin
          if (recCnt == REC_W'(RECOV_TICKS - 1)) state <= ST_IDLE;
          else                                  recCnt <= recCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              intFlag <= 1'b0;
    else if (strobe.commit) intFlag <= 1'b1;
    else if (flagClr)       intFlag <= 1'b0;
  end

  // R3: the conversion clock runs only while a conversion is pending
  p_clk_needs_go_r3: assert property (@(posedge clk) disable iff (!rstN)
    adClkEn |-> goBit);
  // R2: sampling is stopped whenever a conversion is pending
  p_sample_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |-> !goBit);
  // R6: completion clears go and raises the flag together
  p_done_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (intFlag && !goBit));
  // R10: an abort drops go and stops the conversion clock
  p_abort_stops_r10: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (!goBit && !adClkEn));
  // R11: the flag only rises from a completion
  p_flag_source_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intFlag) |-> $past(strobe.commit));
  // R9: a repeated go write does not leave the conversion
  p_ignore_go_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_CONV) && goSet && !lastTick) |=> (state == ST_CONV));
endmodule

// File: rtl/sarConvSeqDatapath.sv
module sarConvSeqDatapath
  import sarConvSeqPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             cmpIn,
  output logic [WIDTH-1:0] dacCode,
  output logic [WIDTH-1:0] result
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] trial, mask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trial  <= '0;
      mask   <= '0;
      result <= '0;
    end else begin
      if (strobe.loadTrial) begin
        trial <= TOP_BIT;
        mask  <= TOP_BIT;
      end else if (strobe.stepBit) begin
        trial <= (cmpIn ? trial : (trial & ~mask)) | (mask >> 1);
        mask  <= mask >> 1;
      end
      if (strobe.commit) result <= trial;
    end
  end

  assign dacCode = trial;

  // R5: exactly one bit is under trial at a time
  p_one_trial_bit_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(mask));
  // R5: no trial step is issued once all bits are resolved
  p_step_in_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepBit |-> (mask != '0));
  // R7: the result only changes on a completion
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(result));
endmodule

// File: rtl/sarConvSeq.sv
module sarConvSeq
  import sarConvSeqPkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int CONV_TICKS  = 11,
  parameter int CLK_DIV     = 4,
  parameter int START_OSC   = 1,
  parameter int INSN_CLKS   = 4,
  parameter int RECOV_TICKS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             goWr,
  input  logic             goWrData,
  input  logic             srcRc,
  input  logic             rcTick,
  input  logic             flagClr,
  input  logic             cmpIn,
  output logic             goBit,
  output logic             sampleEn,
  output logic             adClkEn,
  output logic [WIDTH-1:0] dacCode,
  output logic [WIDTH-1:0] result,
  output logic             intFlag
);
  seqStrobe_t strobe;

  sarConvSeqCtrl #(
    .WIDTH(WIDTH), .CONV_TICKS(CONV_TICKS), .CLK_DIV(CLK_DIV),
    .START_OSC(START_OSC), .INSN_CLKS(INSN_CLKS), .RECOV_TICKS(RECOV_TICKS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .goWr(goWr), .goWrData(goWrData), .srcRc(srcRc),
    .rcTick(rcTick), .flagClr(flagClr), .goBit(goBit), .sampleEn(sampleEn),
    .adClkEn(adClkEn), .intFlag(intFlag), .strobe(strobe)
  );

  sarConvSeqDatapath #(.WIDTH(WIDTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpIn(cmpIn),
    .dacCode(dacCode), .result(result)
  );
endmodule

// File: tb/test_sarConvSeq.sv
`timescale 1ns/1ps
module test_sarConvSeq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic goWr = 1'b0, goWrData = 1'b0, srcRc = 1'b0, rcTick = 1'b0, flagClr = 1'b0;
  logic goBit, sampleEn, adClkEn, intFlag, cmpIn;
  logic [7:0] dacCode, result;
  logic [7:0] vin = 8'h00;
  logic rcRun = 1'b0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign cmpIn = (vin >= dacCode);

  sarConvSeq i_sarConvSeq (
    .clk(clk), .rstN(rstN), .goWr(goWr), .goWrData(goWrData), .srcRc(srcRc),
    .rcTick(rcTick), .flagClr(flagClr), .cmpIn(cmpIn), .goBit(goBit),
    .sampleEn(sampleEn), .adClkEn(adClkEn), .dacCode(dacCode),
    .result(result), .intFlag(intFlag)
  );

  always @(negedge clk) rcTick <= rcRun && ($urandom % 3 == 0);

  // independent bit-serial model of the search for an ideal comparator
  function automatic logic [7:0] expSar(input logic [7:0] v);
    logic [7:0] t = 8'h00;
    for (int b = 7; b >= 0; b--) begin
      t[b] = 1'b1;
      if (!(v >= t)) t[b] = 1'b0;
    end
    return t;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic startGo(input logic src);
    srcRc = src; goWr = 1'b1; goWrData = 1'b1;
    cyc();
    goWr = 1'b0; srcRc = ~src;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (!sampleEn && n < 400) begin cyc(); n++; end
    chk(sampleEn, "R8 recovery ends", sampleEn, 1);
  endtask

  task automatic clearFlag();
    flagClr = 1'b1; cyc(); flagClr = 1'b0;
  endtask

  initial begin
    int n;
    logic [7:0] oldRes;
    void'($urandom(32'd1234));
    repeat (3) cyc();
    // R1 reset state
    chk(goBit == 0 && intFlag == 0 && result == 0 && dacCode == 0, "R1 reset outputs",
        {goBit, intFlag, result, dacCode}, 0);
    chk(sampleEn == 1 && adClkEn == 0, "R1 reset sampling", {sampleEn, adClkEn}, 2);
    rstN = 1'b1;
    cyc();

    // directed: divided clock, exact timing, repeated go write
    vin = 8'hA5;
    startGo(1'b0);
    chk(goBit == 1 && sampleEn == 0, "R2 go accepted", {goBit, sampleEn}, 2);
    chk(adClkEn == 0, "R3 clock not yet", adClkEn, 0);
    n = 0;
    cyc(); n++;
    chk(adClkEn == 1, "R3 osc start delay", adClkEn, 1);
    chk(dacCode == 8'h80, "R5 first trial code", dacCode, 8'h80);
    while (goBit && n < 200) begin
      if (n == 10) begin goWr = 1'b1; goWrData = 1'b1; end
      cyc(); n++;
      goWr = 1'b0;
      if (n == 20) chk(result == 8'h00, "R7 result held mid conversion", result, 0);
    end
    chk(n == 45, "R6 R9 R4 completion edge", n, 45);
    chk(result == expSar(8'hA5), "R5 result", result, expSar(8'hA5));
    chk(intFlag == 1, "R6 flag set", intFlag, 1);
    // recovery: a go write here is ignored
    goWr = 1'b1; goWrData = 1'b1;
    cyc(); goWr = 1'b0;
    chk(goBit == 0, "R8 go ignored in recovery", goBit, 0);
    repeat (6) cyc();
    chk(sampleEn == 0, "R8 still recovering", sampleEn, 0);
    cyc();
    chk(sampleEn == 1, "R8 recovery length", sampleEn, 1);
    repeat (5) cyc();
    chk(intFlag == 1, "R11 flag sticky", intFlag, 1);
    clearFlag();
    chk(intFlag == 0, "R11 flag cleared", intFlag, 0);

    // directed: RC source start delay
    vin = 8'h3C; rcRun = 1'b1;
    startGo(1'b1);
    repeat (4) cyc();
    chk(adClkEn == 0, "R3 rc delay not elapsed", adClkEn, 0);
    cyc();
    chk(adClkEn == 1, "R3 rc start delay", adClkEn, 1);
    n = 0;
    while (goBit && n < 400) begin cyc(); n++; end
    chk(result == expSar(8'h3C), "R4 R5 rc result", result, expSar(8'h3C));
    clearFlag();
    waitIdle();
    rcRun = 1'b0;

    // directed: abort mid conversion
    oldRes = result;
    vin = 8'hFF;
    startGo(1'b0);
    repeat (20) cyc();
    goWr = 1'b1; goWrData = 1'b0;
    cyc(); goWr = 1'b0;
    chk(goBit == 0 && adClkEn == 0, "R10 abort stops", {goBit, adClkEn}, 0);
    repeat (60) cyc();
    chk(result == oldRes, "R10 result unchanged", result, oldRes);
    chk(intFlag == 0, "R10 no flag", intFlag, 0);
    waitIdle();

    // directed: boundary codes
    foreach (vin[i]) ;
    for (int k = 0; k < 2; k++) begin
      vin = (k == 0) ? 8'h00 : 8'hFF;
      startGo(1'b0);
      n = 0;
      while (goBit && n < 200) begin cyc(); n++; end
      chk(result == vin, "R5 boundary code", result, vin);
      clearFlag();
      waitIdle();
    end

    // random
    for (int it = 0; it < 40; it++) begin
      logic src;
      vin = 8'($urandom);
      src = 1'($urandom);
      rcRun = src;
      startGo(src);
      n = 0;
      while (goBit && n < 400) begin cyc(); n++; end
      chk(result == expSar(vin), "R5 random result", result, expSar(vin));
      chk(intFlag == 1, "R6 random flag", intFlag, 1);
      clearFlag();
      waitIdle();
    end
    rcRun = 1'b0;

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule